// File: doc/BRIEF.md
# Two-Level Direct-Indexed Route Lookup

This block resolves a 32-bit IPv4 destination address to a next-hop code by longest-prefix match. It uses two directly indexed tables and no search. The top bits of the address select an entry in the first table. That entry holds either a final next hop or a pointer to a 256-entry block in the second table. In the pointer case, the lowest address byte selects the entry inside the block. Every lookup therefore costs one read, or two reads when a route is more specific than the first-table width.

Software installs routes by expansion. A prefix is written into every entry it covers. Each stored entry keeps a rank derived from its prefix length, so a later write of a shorter covering prefix cannot erase a longer one.

The pipeline has a fixed latency and accepts one lookup per cycle. Each write takes the lookup slot of the cycle in which it is accepted, because the write needs the table's read port to fetch the old rank. The first-table width is a parameter, so the block can be built at a reduced size. At full size it is 24 bits.

Top module: `route_lpm`

## Requirements
- R1: After synchronous reset, `res_valid` is 0 and both `lk_ready` and `wr_ready` are 1. Lookups in tables that were never written return the no-route code, all ones (8'hFF by default).
- R2: A lookup accepted at clock edge n (`lk_valid` and `lk_ready` both high) makes `res_valid` high in the cycle after edge n+2, carrying that lookup's result. Results come out in request order, and a lookup can be accepted on every edge.
- R3: The first-table index is `lk_addr[31 -: L1_BITS]`. If the entry there has its pointer flag at 0, that entry's stored next hop is the result.
- R4: If the first-table entry has its pointer flag at 1, the second-table index is {pointer base, `lk_addr[7:0]`}, and the result is the next hop stored at that index.
- R5: A never-written entry at either level, including an empty slot inside a pointed-to block, returns the no-route code.
- R6: A next-hop write (`wr_level` 0 = first table, 1 = second table; `wr_index` LSB-aligned; `wr_plen` 0..32, larger values treated as 32) replaces the stored entry only if its prefix length is equal to or longer than the stored one. Otherwise the stored entry is kept.
- R7: A first-table write with `wr_ptr`=1 installs pointer base `wr_value` and always replaces the entry. A later next-hop write to that first-table entry leaves the pointer in place. `wr_ptr` has no effect on second-table writes.
- R8: In the cycle in which a write is accepted (`wr_valid` and `wr_ready` both high), `lk_ready` is 0. After a first-table write is accepted, `wr_ready` is 0 for one cycle; after a second-table write, for two cycles.
- R9: A write accepted at edge W affects lookups accepted at edge W+2 and later. A lookup accepted at edge W+1 still sees the earlier contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted this cycle |
| lk_addr | input | ADDR_W | Destination address to resolve |
| res_valid | output | 1 | Result present |
| res_nh | output | NH_W | Next-hop code or no-route code |
| wr_valid | input | 1 | Table write request present |
| wr_ready | output | 1 | Write can be accepted this cycle |
| wr_level | input | 1 | 0 = first table, 1 = second table |
| wr_ptr | input | 1 | First table only: install a pointer instead of a next hop |
| wr_index | input | IDX_W | Entry index within the chosen table |
| wr_plen | input | 6 | Prefix length of the route being installed |
| wr_value | input | VAL_W | Next hop, or pointer base when `wr_ptr` is 1 |

## Verification
The hardest case to reach from the ports is a write landing on an entry while lookups to that same entry stream past every cycle. Only in that case does the one-cycle window between the old and new contents show, and with it the slot the write steals. The stimulus holds `lk_valid` high on a handful of first-table indices and low address bytes while a second process issues writes of mixed prefix lengths to the same indices. Some of those writes are pointer installs, so results switch between one-read and two-read paths. A behavioural model applies each write one edge after acceptance and predicts `lk_ready`, `wr_ready` and every result on every clock.

// File: rtl/route_lpm_pkg.sv
package route_lpm_pkg;

  localparam int PLEN_W = 6;
  localparam logic [PLEN_W-1:0] RANK_PTR = '1;

  typedef enum logic {
    LVL_TOP = 1'b0,
    LVL_SUB = 1'b1
  } lvl_e;

  // rank 0 marks an empty entry; installed routes rank 1..33
  function automatic logic [PLEN_W-1:0] rank_of(input logic [PLEN_W-1:0] plen);
    return (plen > 6'd32) ? 6'd33 : plen + 6'd1;
  endfunction

  function automatic logic may_replace(input logic [PLEN_W-1:0] old_rank,
                                       input logic [PLEN_W-1:0] new_rank,
                                       input logic              new_ptr);
    if (new_ptr) return 1'b1;
    if (old_rank == RANK_PTR) return 1'b0;
    return new_rank >= old_rank;
  endfunction

endpackage

// File: rtl/route_lpm_ram.sv
module route_lpm_ram #(
  parameter int AW = 10,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);

  logic [DW-1:0] mem [DEPTH] = '{default: '0};

  // read-first simple dual port: a same-edge write is seen one read later
  always_ff @(posedge clk) begin
    rd_data <= mem[rd_addr];
    if (wr_en) mem[wr_addr] <= wr_data;
  end

endmodule

// File: rtl/route_lpm_writer.sv
module route_lpm_writer
  import route_lpm_pkg::*;
#(
  parameter int IDX_W = 11,
  parameter int L2_AW = 11,
  parameter int VAL_W = 8,
  parameter int NH_W  = 8,
  localparam int L1_DW = PLEN_W + 1 + VAL_W,
  localparam int L2_DW = PLEN_W + NH_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_level,
  input  logic              wr_ptr,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [PLEN_W-1:0] wr_plen,
  input  logic [VAL_W-1:0]  wr_value,
  output logic              lk_block,
  output logic              take_top,
  output logic              take_sub,
  output logic [L2_AW-1:0]  sub_idx,
  input  logic [PLEN_W-1:0] top_old_rank,
  input  logic [PLEN_W-1:0] sub_old_rank,
  output logic              top_we,
  output logic [L1_DW-1:0]  top_wdata,
  output logic              sub_we,
  output logic [L2_DW-1:0]  sub_wdata
);

  logic              pend_a;
  logic              pend_b;
  lvl_e              h_lvl;
  logic              h_ptr;
  logic [PLEN_W-1:0] h_rank;
  logic [VAL_W-1:0]  h_val;
  logic [L2_AW-1:0]  h_sub;
  logic              accept;

  assign wr_ready = !pend_a && !pend_b;
  assign accept   = wr_valid && wr_ready;
  assign lk_block = accept;
  assign take_top = accept && (wr_level == LVL_TOP);
  assign take_sub = pend_a && (h_lvl == LVL_SUB);
  assign sub_idx  = h_sub;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_a <= 1'b0;
      pend_b <= 1'b0;
    end else begin
      pend_a <= accept;
      pend_b <= pend_a && (h_lvl == LVL_SUB);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      h_lvl  <= lvl_e'(wr_level);
      h_ptr  <= wr_ptr && (wr_level == LVL_TOP);
      h_rank <= rank_of(wr_plen);
      h_val  <= wr_value;
      h_sub  <= wr_index[L2_AW-1:0];
    end
  end

  // first table: old entry was read at the accepting edge, decide one edge later
  assign top_we    = pend_a && (h_lvl == LVL_TOP) && may_replace(top_old_rank, h_rank, h_ptr);
  assign top_wdata = {(h_ptr ? RANK_PTR : h_rank), h_ptr, h_val};

  // second table: old entry read one edge after accept, decide on the next
  assign sub_we    = pend_b && may_replace(sub_old_rank, h_rank, 1'b0);
  assign sub_wdata = {h_rank, h_val[NH_W-1:0]};

endmodule

// File: rtl/route_lpm_pick.sv
module route_lpm_pick
  import route_lpm_pkg::*;
#(
  parameter int NH_W = 8,
  parameter logic [NH_W-1:0] NO_ROUTE = '1
) (
  input  logic              via_ptr,
  input  logic              top_empty,
  input  logic [NH_W-1:0]   top_nh,
  input  logic [PLEN_W-1:0] sub_rank,
  input  logic [NH_W-1:0]   sub_nh,
  output logic [NH_W-1:0]   nh
);

  always_comb begin
    if (via_ptr)        nh = (sub_rank == '0) ? NO_ROUTE : sub_nh;
    else if (top_empty) nh = NO_ROUTE;
    else                nh = top_nh;
  end

endmodule

// File: rtl/route_lpm.sv
module route_lpm
  import route_lpm_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int L1_BITS   = 10,
  parameter int SUB_BITS  = 8,
  parameter int L2_BLOCKS = 8,
  parameter int NH_W      = 8,
  parameter logic [NH_W-1:0] NO_ROUTE = '1,
  localparam int PTR_W = (L2_BLOCKS > 1) ? $clog2(L2_BLOCKS) : 1,
  localparam int L2_AW = PTR_W + SUB_BITS,
  localparam int VAL_W = (NH_W > PTR_W) ? NH_W : PTR_W,
  localparam int IDX_W = (L1_BITS > L2_AW) ? L1_BITS : L2_AW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              res_valid,
  output logic [NH_W-1:0]   res_nh,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic              wr_level,
  input  logic              wr_ptr,
  input  logic [IDX_W-1:0]  wr_index,
  input  logic [PLEN_W-1:0] wr_plen,
  input  logic [VAL_W-1:0]  wr_value
);

  localparam int L1_DW = PLEN_W + 1 + VAL_W;
  localparam int L2_DW = PLEN_W + NH_W;
  localparam int MID_W = ADDR_W - L1_BITS - SUB_BITS;

  // address bits between the two index fields are unused at reduced size
  generate
    if (MID_W > 0) begin : g_mid
      logic mid_unused;
      assign mid_unused = ^lk_addr[SUB_BITS +: MID_W];
    end
  endgenerate

  logic               lk_block;
  logic               take_top;
  logic               take_sub;
  logic [L2_AW-1:0]   sub_idx;
  logic               top_we;
  logic [L1_DW-1:0]   top_wdata;
  logic               sub_we;
  logic [L2_DW-1:0]   sub_wdata;
  logic [L1_BITS-1:0] top_raddr;
  logic [L1_DW-1:0]   top_q;
  logic [L2_AW-1:0]   sub_raddr;
  logic [L2_DW-1:0]   sub_q;
  logic               lk_fire;

  assign lk_ready = !lk_block;
  assign lk_fire  = lk_valid && lk_ready;

  route_lpm_writer #(
    .IDX_W(IDX_W), .L2_AW(L2_AW), .VAL_W(VAL_W), .NH_W(NH_W)
  ) u_writer (
    .clk(clk), .rst(rst),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_level(wr_level),
    .wr_ptr(wr_ptr), .wr_index(wr_index), .wr_plen(wr_plen), .wr_value(wr_value),
    .lk_block(lk_block), .take_top(take_top), .take_sub(take_sub), .sub_idx(sub_idx),
    .top_old_rank(top_q[L1_DW-1 -: PLEN_W]), .sub_old_rank(sub_q[L2_DW-1 -: PLEN_W]),
    .top_we(top_we), .top_wdata(top_wdata), .sub_we(sub_we), .sub_wdata(sub_wdata)
  );

  // stage 0: first-table read, shared with a write that fetches its old rank
  assign top_raddr = take_top ? wr_index[L1_BITS-1:0] : lk_addr[ADDR_W-1 -: L1_BITS];

  route_lpm_ram #(.AW(L1_BITS), .DW(L1_DW)) u_top_tbl (
    .clk(clk), .rd_addr(top_raddr), .rd_data(top_q),
    .wr_en(top_we), .wr_addr(sub_idx_top(wr_index_q)), .wr_data(top_wdata)
  );

  // hold the first-table write index alongside the writer's pending state
  logic [L1_BITS-1:0] wr_index_q;
  always_ff @(posedge clk) begin
    if (take_top) wr_index_q <= wr_index[L1_BITS-1:0];
  end

  function automatic logic [L1_BITS-1:0] sub_idx_top(input logic [L1_BITS-1:0] v);
    return v;
  endfunction

  logic                s1_valid;
  logic [SUB_BITS-1:0] s1_off;

  always_ff @(posedge clk) begin
    if (rst) s1_valid <= 1'b0;
    else     s1_valid <= lk_fire;
    s1_off <= lk_addr[SUB_BITS-1:0];
  end

  // stage 1: decode first-table entry, second-table read
  logic [PLEN_W-1:0] top_rank;
  logic              top_flag;
  logic [VAL_W-1:0]  top_val;

  assign top_rank  = top_q[L1_DW-1 -: PLEN_W];
  assign top_flag  = top_q[VAL_W];
  assign top_val   = top_q[VAL_W-1:0];
  assign sub_raddr = take_sub ? sub_idx : {top_val[PTR_W-1:0], s1_off};

  route_lpm_ram #(.AW(L2_AW), .DW(L2_DW)) u_sub_tbl (
    .clk(clk), .rd_addr(sub_raddr), .rd_data(sub_q),
    .wr_en(sub_we), .wr_addr(sub_idx), .wr_data(sub_wdata)
  );

  logic            s2_valid;
  logic            s2_ptr;
  logic            s2_empty;
  logic [NH_W-1:0] s2_nh;

  always_ff @(posedge clk) begin
    if (rst) s2_valid <= 1'b0;
    else     s2_valid <= s1_valid;
    s2_ptr   <= top_flag;
    s2_empty <= (top_rank == '0);
    s2_nh    <= top_val[NH_W-1:0];
  end

  // stage 2: choose between the one-read and two-read result
  logic [NH_W-1:0] pick_nh;

  route_lpm_pick #(.NH_W(NH_W), .NO_ROUTE(NO_ROUTE)) u_pick (
    .via_ptr(s2_ptr), .top_empty(s2_empty), .top_nh(s2_nh),
    .sub_rank(sub_q[L2_DW-1 -: PLEN_W]), .sub_nh(sub_q[NH_W-1:0]), .nh(pick_nh)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_nh    <= '0;
    end else begin
      res_valid <= s2_valid;
      if (s2_valid) res_nh <= pick_nh;
    end
  end

endmodule

// File: rtl/route_lpm_chk.sv
module route_lpm_chk #(
  parameter int NH_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            lk_valid,
  input logic            lk_ready,
  input logic            wr_valid,
  input logic            wr_ready,
  input logic            wr_level,
  input logic            res_valid,
  input logic [NH_W-1:0] res_nh,
  input logic            top_we,
  input logic            sub_we
);

  logic [2:0] fire_d;

  always_ff @(posedge clk) begin
    if (rst) fire_d <= '0;
    else     fire_d <= {fire_d[1:0], lk_valid && lk_ready};
  end

  AST_FIXED_DELAY: assert property (@(posedge clk) disable iff (rst)
    res_valid == fire_d[2]);  // R2

  AST_RES_DEFINED: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !$isunknown(res_nh));  // R2

  AST_WRITE_TAKES_SLOT: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |-> !lk_ready);  // R8

  AST_WRITE_GAP: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && wr_ready) |=> !wr_ready);  // R8

  AST_TOP_COMMIT_EDGE: assert property (@(posedge clk) disable iff (rst)
    top_we |-> $past(wr_valid && wr_ready && !wr_level));  // R9

  AST_SUB_COMMIT_EDGE: assert property (@(posedge clk) disable iff (rst)
    sub_we |-> $past(wr_valid && wr_ready && wr_level, 2));  // R9

endmodule

bind route_lpm route_lpm_chk #(.NH_W(NH_W)) u_chk (
  .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_level(wr_level),
  .res_valid(res_valid), .res_nh(res_nh), .top_we(top_we), .sub_we(sub_we)
);

// File: tb/route_lpm_test.sv
`timescale 1ns/1ps
module route_lpm_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_valid = 1'b0;
  logic        lk_ready;
  logic [31:0] lk_addr = '0;
  logic        res_valid;
  logic [7:0]  res_nh;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic        wr_level = 1'b0;
  logic        wr_ptr = 1'b0;
  logic [10:0] wr_index = '0;
  logic [5:0]  wr_plen = '0;
  logic [7:0]  wr_value = '0;

  always #5 clk = ~clk;

  route_lpm uut (
    .clk(clk), .rst(rst), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .res_valid(res_valid), .res_nh(res_nh), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_level(wr_level), .wr_ptr(wr_ptr), .wr_index(wr_index), .wr_plen(wr_plen),
    .wr_value(wr_value)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 0;
  string tag = "R1";

  // behavioural reference: tables, delayed commit, result shift
  int m1_rank [1024];
  int m1_flag [1024];
  int m1_val  [1024];
  int m2_rank [2048];
  int m2_val  [2048];
  int busy;
  bit p1_v, p2_v, o_v;
  int p1_nh, p2_nh, o_nh;
  bit pw_v;
  int pw_lvl, pw_idx, pw_ptr, pw_rank, pw_val;
  bit lk_acc, wr_acc;

  initial begin
    for (int i = 0; i < 1024; i++) begin m1_rank[i] = 0; m1_flag[i] = 0; m1_val[i] = 0; end
    for (int i = 0; i < 2048; i++) begin m2_rank[i] = 0; m2_val[i] = 0; end
  end

  function automatic int m_look(input logic [31:0] a);
    int i, j;
    i = int'(a[31:22]);
    if (m1_rank[i] == 0) return 255;
    if (m1_flag[i] == 0) return m1_val[i];
    j = (m1_val[i] % 8) * 256 + int'(a[7:0]);
    if (m2_rank[j] == 0) return 255;
    return m2_val[j];
  endfunction

  task automatic m_commit();
    if (pw_lvl == 0) begin
      int i = pw_idx % 1024;
      if (pw_ptr != 0) begin
        m1_rank[i] = 63; m1_flag[i] = 1; m1_val[i] = pw_val;
      end else if (m1_flag[i] == 0 && pw_rank >= m1_rank[i]) begin
        m1_rank[i] = pw_rank; m1_val[i] = pw_val;
      end
    end else begin
      int j = pw_idx % 2048;
      if (pw_rank >= m2_rank[j]) begin
        m2_rank[j] = pw_rank; m2_val[j] = pw_val;
      end
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      busy = 0; p1_v = 0; p2_v = 0; o_v = 0; pw_v = 0; lk_acc = 0; wr_acc = 0;
    end else begin
      bit wa, la;
      wa = wr_valid && (busy == 0);
      la = lk_valid && !wa;
      o_v = p2_v; o_nh = p2_nh;
      p2_v = p1_v; p2_nh = p1_nh;
      p1_v = la;
      if (la) p1_nh = m_look(lk_addr);
      if (pw_v) m_commit();
      pw_v = wa;
      if (wa) begin
        pw_lvl = int'(wr_level); pw_idx = int'(wr_index); pw_ptr = int'(wr_ptr && !wr_level);
        pw_rank = (wr_plen > 32) ? 33 : int'(wr_plen) + 1; pw_val = int'(wr_value);
        busy = wr_level ? 2 : 1;
      end else if (busy > 0) busy = busy - 1;
      lk_acc = la; wr_acc = wa;
    end
  end

  task automatic expect_eq(input string rq, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst && !done) begin
      expect_eq("R8", "wr_ready", int'(wr_ready), int'(busy == 0));
      expect_eq("R8", "lk_ready", int'(lk_ready), int'(!(wr_valid && busy == 0)));
      expect_eq("R2", "res_valid", int'(res_valid), int'(o_v));
      if (o_v) expect_eq(tag, "res_nh", int'(res_nh), o_nh);
    end
  end

  function automatic logic [31:0] mk(input int idx, input int off);
    logic [31:0] a;
    a = $urandom;
    a[31:22] = idx[9:0];
    a[7:0] = off[7:0];
    return a;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic lk_one(input logic [31:0] a);
    lk_valid = 1'b1; lk_addr = a;
    do @(negedge clk); while (!lk_acc);
    #1;
  endtask

  task automatic lk_stop();
    lk_valid = 1'b0;
  endtask

  task automatic wr_one(input int lvl, input int idx, input int ptr, input int plen, input int val);
    wr_valid = 1'b1; wr_level = lvl[0]; wr_index = idx[10:0]; wr_ptr = ptr[0];
    wr_plen = plen[5:0]; wr_value = val[7:0];
    do @(negedge clk); while (!wr_acc);
    #1;
    wr_valid = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL %s watchdog: actual %0d expected %0d", tag, 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    rst = 1'b0;
    @(negedge clk);
    // R1: state right after reset
    expect_eq("R1", "lk_ready after reset", int'(lk_ready), 1);
    expect_eq("R1", "wr_ready after reset", int'(wr_ready), 1);
    expect_eq("R1", "res_valid after reset", int'(res_valid), 0);
    #1;
    tag = "R1";
    lk_one(mk(0, 0)); lk_one(mk(1023, 255)); lk_one(mk(17, 3)); lk_stop(); idle(4);

    tag = "R3";
    wr_one(0, 5, 0, 20, 8'h21);
    wr_one(0, 1023, 0, 24, 8'h33);
    wr_one(0, 0, 0, 8, 8'h10);
    idle(2);
    lk_one(mk(5, 9)); lk_one(mk(1023, 0)); lk_one(mk(0, 200));
    tag = "R5";
    lk_one(mk(6, 1)); lk_stop(); idle(4);

    tag = "R2";
    for (int k = 0; k < 24; k++) lk_one(mk((k % 3 == 0) ? 5 : (k % 3 == 1) ? 1023 : 6, k));
    lk_stop(); idle(4);

    tag = "R4";
    wr_one(0, 7, 1, 0, 3);
    wr_one(1, 3 * 256 + 8'h10, 0, 28, 8'h44);
    wr_one(1, 3 * 256 + 8'hFF, 0, 32, 8'h55);
    idle(2);
    lk_one(mk(7, 8'h10)); lk_one(mk(7, 8'hFF));
    tag = "R5";
    lk_one(mk(7, 8'h11)); lk_stop(); idle(4);

    tag = "R6";
    wr_one(0, 9, 0, 16, 5);  wr_one(0, 9, 0, 8, 9);   idle(2); lk_one(mk(9, 0)); lk_stop();
    wr_one(0, 9, 0, 16, 6);  idle(2); lk_one(mk(9, 0)); lk_stop();
    wr_one(0, 9, 0, 20, 7);  idle(2); lk_one(mk(9, 0)); lk_stop();
    wr_one(1, 3 * 256 + 8'h10, 0, 25, 8'h66); idle(2); lk_one(mk(7, 8'h10)); lk_stop();
    wr_one(1, 3 * 256 + 8'h10, 0, 28, 8'h67); idle(2); lk_one(mk(7, 8'h10)); lk_stop();
    idle(4);

    tag = "R7";
    wr_one(0, 7, 0, 32, 8'h77); idle(2); lk_one(mk(7, 8'hFF)); lk_stop();
    wr_one(0, 5, 1, 0, 2); idle(2); lk_one(mk(5, 4)); lk_stop();
    wr_one(1, 1 * 256 + 4, 1, 24, 8'h19); wr_one(0, 11, 1, 0, 1); idle(2);
    lk_one(mk(11, 4)); lk_stop(); idle(4);

    tag = "R9";
    fork
      begin
        for (int k = 0; k < 40; k++) lk_one(mk(12 + (k % 2), 4));
        lk_stop();
      end
      begin
        idle(3); wr_one(0, 12, 0, 10, 8'h12);
        idle(4); wr_one(0, 13, 1, 0, 1);
        idle(3); wr_one(0, 12, 0, 12, 8'h13);
        idle(2); wr_one(1, 1 * 256 + 4, 0, 30, 8'h29);
      end
    join
    idle(4);

    tag = "R8";
    fork
      begin
        for (int k = 0; k < 300; k++) lk_one(mk($urandom_range(0, 15), $urandom_range(0, 15)));
        lk_stop();
      end
      begin
        for (int k = 0; k < 70; k++) begin
          int lvl = $urandom_range(0, 1);
          int p = ($urandom_range(0, 9) == 0) ? 1 : 0;
          idle($urandom_range(0, 3));
          if (lvl == 0)
            wr_one(0, $urandom_range(0, 15), p, $urandom_range(0, 32), p ? $urandom_range(0, 7) : $urandom_range(0, 254));
          else
            wr_one(1, $urandom_range(0, 7) * 256 + $urandom_range(0, 15), 0, $urandom_range(0, 32), $urandom_range(0, 254));
        end
      end
    join
    idle(6);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule